// File: doc/BRIEF.md
# Coprocessor Error Sideband Handler

This block sits between a processor's floating-point error pin and the rest of the chipset. It watches the active-low error indication coming from the processor. While the error is present, it raises a level interrupt request on line 13 toward the interrupt controller. Software acknowledges the error by writing to a fixed I/O port, and the block then asserts the active-low "ignore numeric error" output back to the processor. That output stays asserted until the processor withdraws its error indication.

A single enable bit from a general control register gates the whole function. With the bit clear, no interrupt request is raised and the ignore output is held inactive. While the chip is in reset, the ignore pin carries a frequency strap value instead of its normal function.

The error input is asynchronous and passes through a two-flop synchronizer before any logic uses it. The port decode is a single compare of the write address against a parameterized port number, qualified by a write strobe.

Top module: `fpu_err_sideband`

## Requirements
- R1: The error input passes through a two-stage synchronizer. A change on `fpu_err_n` reaches the synchronized error, and therefore `irq13`, after exactly two rising clock edges.
- R2: `irq13` is high exactly when `func_en` is 1 and the synchronized error is active. It falls as soon as `func_en` is cleared.
- R3: A cycle with `io_wr`=1, `io_addr`=ACK_PORT (default 16'h00F0) and `func_en`=1, while the synchronized error is active, drives `ignore_err_n` low from the next rising edge.
- R4: Once low, `ignore_err_n` stays low through further acknowledge writes. It returns high on the rising edge after the synchronized error goes inactive, which is three edges after `fpu_err_n` returns high.
- R5: An acknowledge write while the synchronized error is inactive leaves `ignore_err_n` high.
- R6: Clearing `func_en` drives `ignore_err_n` high on the next rising edge. Writes made while disabled do not assert it. Setting `func_en` again does not re-assert the output without a new write.
- R7: A write strobe with any address other than ACK_PORT has no effect on `ignore_err_n`.
- R8: While `rst_n` is low, `ignore_err_n` equals `strap_ign` and `irq13` is low. After reset is released, `ignore_err_n` is high (inactive) until the first valid acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_ign | input | 1 | Strap level driven on the ignore pin during reset |
| func_en | input | 1 | Coprocessor error reporting enable bit |
| fpu_err_n | input | 1 | Asynchronous active-low error from the processor |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | ADDR_W | I/O write address |
| ignore_err_n | output | 1 | Active-low ignore-numeric-error to the processor |
| irq13 | output | 1 | Level interrupt request, line 13 |

## Verification
The bench targets four corner cases:
- **Arming write while the error is absent.** A design that armed on any port hit would pull the ignore pin low with no error pending.
- **Release path.** The bench counts the three-edge delay after the error input drops. It also checks that repeated writes do not toggle the output, which a design releasing on a second write would get wrong.
- **Disable and re-enable with the error still present.** This catches a design that keeps, or silently re-arms, the ignore output.
- **Reset strap.** The strap is applied at both levels, which exposes a design that drives a constant during reset.

Random traffic mixing near-miss addresses, error toggles and enable flips is compared each cycle against a reference model.

// File: rtl/fpu_err_sideband.sv
module fpu_err_sideband #(
  parameter int unsigned ADDR_W      = 16,
  parameter logic [15:0] ACK_PORT    = 16'h00F0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_ign,
  input  logic              func_en,
  input  logic              fpu_err_n,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              ignore_err_n,
  output logic              irq13
);

  localparam logic [ADDR_W-1:0] PORT_MATCH = ADDR_W'(ACK_PORT);

  logic [SYNC_STAGES-1:0] err_pipe;
  logic                   err_sync;
  logic                   ack_hit;
  logic                   ign_q;
  logic                   ign_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_pipe <= '0;
    else        err_pipe <= {err_pipe[SYNC_STAGES-2:0], ~fpu_err_n};
  end

  assign err_sync = err_pipe[SYNC_STAGES-1];
  assign ack_hit  = io_wr && (io_addr == PORT_MATCH);

  always_comb begin
    ign_d = ign_q;
    if (!func_en || !err_sync) ign_d = 1'b0;
    else if (ack_hit)          ign_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ign_q <= 1'b0;
    else        ign_q <= ign_d;
  end

  assign irq13        = func_en && err_sync;
  assign ignore_err_n = rst_n ? ~ign_q : strap_ign;

  p_release_after_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ign_q && !err_sync) |=> !ign_q);

  p_arm_only_by_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ign_q) |-> $past(ack_hit && err_sync && func_en));

  p_disable_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !func_en |=> !ign_q);

  p_hold_while_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (func_en && err_sync && ign_q) |=> ign_q);

  p_no_arm_without_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_sync && !ign_q) |=> !ign_q);

endmodule

// File: tb/fpu_err_sideband_tb.sv
module fpu_err_sideband_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_ign = 1'b1;
  logic        func_en = 1'b0;
  logic        fpu_err_n = 1'b1;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        ignore_err_n;
  logic        irq13;
  int          checks = 0;
  int          errors = 0;
  logic        m_s1, m_s2, m_ign;

  always #5 clk = ~clk;

  fpu_err_sideband u_dut (
    .clk(clk), .rst_n(rst_n), .strap_ign(strap_ign), .func_en(func_en),
    .fpu_err_n(fpu_err_n), .io_wr(io_wr), .io_addr(io_addr),
    .ignore_err_n(ignore_err_n), .irq13(irq13)
  );

  function automatic logic next_ign(logic en, logic err, logic wr, logic [15:0] a, logic cur);
    if (!en || !err) return 1'b0;
    if (wr && a == 16'h00F0) return 1'b1;
    return cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b0; m_s2 <= 1'b0; m_ign <= 1'b0;
    end else begin
      m_s1  <= ~fpu_err_n;
      m_s2  <= m_s1;
      m_ign <= next_ign(func_en, m_s2, io_wr, io_addr, m_ign);
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack(logic [15:0] a);
    io_wr = 1'b1; io_addr = a;
    step(1);
    io_wr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(2);
    chk("R8 strap high ign", ignore_err_n, 1'b1);
    chk("R8 irq in reset", irq13, 1'b0);
    strap_ign = 1'b0; #1;
    chk("R8 strap low ign", ignore_err_n, 1'b0);
    step(1);
    rst_n = 1'b1;
    step(1);
    chk("R8 ign after reset", ignore_err_n, 1'b1);
    chk("R8 irq after reset", irq13, 1'b0);

    func_en = 1'b1;
    ack(16'h00F0);
    step(1);
    chk("R5 write without error", ignore_err_n, 1'b1);

    fpu_err_n = 1'b0;
    step(1);
    chk("R1 irq after one edge", irq13, 1'b0);
    step(1);
    chk("R1 irq after two edges", irq13, 1'b1);
    chk("R2 irq level", irq13, 1'b1);

    ack(16'h00F1);
    chk("R7 wrong port", ignore_err_n, 1'b1);
    ack(16'h01F0);
    chk("R7 wrong high byte", ignore_err_n, 1'b1);
    ack(16'h00F0);
    chk("R3 armed by write", ignore_err_n, 1'b0);
    step(5);
    chk("R4 holds", ignore_err_n, 1'b0);
    ack(16'h00F0);
    chk("R4 second write keeps", ignore_err_n, 1'b0);

    fpu_err_n = 1'b1;
    step(1);
    chk("R4 edge1", ignore_err_n, 1'b0);
    step(1);
    chk("R4 edge2", ignore_err_n, 1'b0);
    chk("R2 irq drops", irq13, 1'b0);
    step(1);
    chk("R4 released edge3", ignore_err_n, 1'b1);

    fpu_err_n = 1'b0;
    step(2);
    ack(16'h00F0);
    chk("R3 re-armed", ignore_err_n, 1'b0);
    func_en = 1'b0; #1;
    chk("R2 irq off when disabled", irq13, 1'b0);
    step(1);
    chk("R6 disable clears", ignore_err_n, 1'b1);
    ack(16'h00F0);
    chk("R6 write while disabled", ignore_err_n, 1'b1);
    func_en = 1'b1;
    step(2);
    chk("R6 no re-arm on enable", ignore_err_n, 1'b1);
    chk("R2 irq back", irq13, 1'b1);

    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] r;
      r = 4'($urandom_range(15));
      if (r == 0) fpu_err_n = ~fpu_err_n;
      if ($urandom_range(39) == 0) func_en = ~func_en;
      io_wr = ($urandom_range(3) == 0);
      case ($urandom_range(3))
        0: io_addr = 16'($urandom);
        1: io_addr = 16'h00F0 ^ (16'h1 << $urandom_range(15));
        default: io_addr = 16'h00F0;
      endcase
      step(1);
      chk("R3/R4 random ign", ignore_err_n, ~m_ign);
      chk("R2 random irq", irq13, func_en & m_s2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule